// File: doc/BRIEF.md
# Hub Interrupt Status Change Reporter

This block holds the change bitmap behind a hub's interrupt endpoint. A hub-level change flag and one change flag per downstream port feed it. The bitmap captures these flags only when the end-of-frame sample strobe fires. Each captured bit then stays set until the host clears it by index.

When an IN token for the endpoint arrives, the block answers one cycle later. It returns the whole bitmap byte if any bit is set. It returns a NAK if the bitmap is empty or the hub is not configured. While the hub is unconfigured the bitmap is flushed and nothing is captured. Token decoding, packet serialisation and CRC are handled elsewhere.

Top module: `hub_chg_reporter`

## Requirements
- R1: Bitmap layout: bit 0 holds the hub change, bit k (k = 1..NUM_PORTS) holds `port_chg_i[k-1]`, and every bit above NUM_PORTS in the returned byte is zero.
- R2: Source flags are captured only in cycles where `eof_smp_i` is high. Source values in any other cycle leave the bitmap unchanged.
- R3: A captured bit stays set across any number of polls until it is cleared, the hub is deconfigured, or reset is applied.
- R4: A clear request (`clr_req_i` high) clears the bit selected by `clr_idx_i`, where 0 selects the hub and 1..NUM_PORTS select the ports. Index values above NUM_PORTS change nothing.
- R5: If a capture and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: An IN token in cycle n makes `rsp_valid_o` high for exactly cycle n+1. When the bitmap is non-zero, `rsp_nak_o` is 0 and `rsp_data_o` carries the bitmap. In all cycles without a response, all three outputs are 0.
- R7: An IN token that sees an empty bitmap gives `rsp_nak_o` = 1 with `rsp_data_o` = 0.
- R8: While `cfg_i` is low the bitmap is flushed, capture is suppressed, and any IN token gets a NAK.
- R9: A response carries the bitmap as it stood in the token cycle, not counting captures or clears made in that same cycle.
- R10: After reset the bitmap is empty and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 1 | Hub is configured |
| hub_chg_i | input | 1 | Hub-level change flag |
| port_chg_i | input | NUM_PORTS | Per-port change flags, bit 0 = port 1 |
| eof_smp_i | input | 1 | End-of-frame sample strobe |
| clr_req_i | input | 1 | Clear request strobe |
| clr_idx_i | input | IDX_W | Bit index to clear |
| in_tok_i | input | 1 | IN token strobe for this endpoint |
| rsp_valid_o | output | 1 | Response present this cycle |
| rsp_nak_o | output | 1 | Response is a NAK |
| rsp_data_o | output | MAP_W | Response byte |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- A flag raised outside the sample strobe. A design that samples continuously would report it.
- A clear and a capture hitting the same bit in one cycle. A design that gives the clear priority would lose the event.
- A clear index past the last port. A design that decodes only the low index bits would wipe a real port bit.
- A token arriving together with a capture. A design that answers from the updated bitmap would return data where a NAK is due.
- Deconfiguration and reset in the middle of a run. A design that skips these would keep stale bits and return them.
- All sources set at once. This exposes leakage into the reserved high bits.

// File: rtl/hub_chg_pkg.sv
package hub_chg_pkg;
  localparam int HUB_BIT = 0;

  typedef struct packed {
    logic valid;
    logic nak;
  } rsp_flags_t;
endpackage

// File: rtl/chg_bit_cell.sv
module chg_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // priority: flush, then set, then clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (flush_i) q_o <= 1'b0;
    else if (set_i)   q_o <= 1'b1;
    else if (clr_i)   q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !flush_i |=> q_o); // R5
  AST_BIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !clr_i && !flush_i |=> $stable(q_o)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !q_o); // R8
endmodule

// File: rtl/chg_rsp_gen.sv
module chg_rsp_gen
  import hub_chg_pkg::*;
#(
  parameter int MAP_W = 8,
  parameter int SRC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_tok_i,
  input  logic             cfg_i,
  input  logic [SRC_W-1:0] map_i,
  output logic             rsp_valid_o,
  output logic             rsp_nak_o,
  output logic [MAP_W-1:0] rsp_data_o
);
  rsp_flags_t       flags_d, flags_q;
  logic [MAP_W-1:0] data_d;
  logic             has_chg;

  assign has_chg = cfg_i && (map_i != '0);

  always_comb begin
    flags_d = '0;
    data_d  = '0;
    if (in_tok_i) begin
      flags_d.valid = 1'b1;
      flags_d.nak   = !has_chg;
      if (has_chg) data_d[SRC_W-1:0] = map_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q    <= '0;
      rsp_data_o <= '0;
    end else begin
      flags_q    <= flags_d;
      rsp_data_o <= data_d;
    end
  end

  assign rsp_valid_o = flags_q.valid;
  assign rsp_nak_o   = flags_q.nak;

  AST_TOK_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_tok_i |=> rsp_valid_o); // R6
  AST_NO_TOK_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_tok_i |=> !rsp_valid_o && !rsp_nak_o && rsp_data_o == '0); // R6
  AST_NAK_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_nak_o |-> rsp_valid_o && rsp_data_o == '0); // R7
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_data_o >> SRC_W) == '0); // R1
  AST_UNCFG_NAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_tok_i && !cfg_i |=> rsp_nak_o); // R8
endmodule

// File: rtl/hub_chg_reporter.sv
module hub_chg_reporter
  import hub_chg_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  parameter  int MAP_W     = 8,
  localparam int SRC_W     = NUM_PORTS + 1,
  localparam int IDX_W     = $clog2(MAP_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_i,
  input  logic                 hub_chg_i,
  input  logic [NUM_PORTS-1:0] port_chg_i,
  input  logic                 eof_smp_i,
  input  logic                 clr_req_i,
  input  logic [IDX_W-1:0]     clr_idx_i,
  input  logic                 in_tok_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_nak_o,
  output logic [MAP_W-1:0]     rsp_data_o
);
  logic [SRC_W-1:0] src, set_vec, clr_vec, map_q;

  always_comb begin
    src          = '0;
    src[HUB_BIT] = hub_chg_i;
    src[SRC_W-1:1] = port_chg_i;
  end

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    assign set_vec[i] = eof_smp_i && cfg_i && src[i];
    assign clr_vec[i] = clr_req_i && (clr_idx_i == IDX_W'(i));

    chg_bit_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (!cfg_i),
      .set_i   (set_vec[i]),
      .clr_i   (clr_vec[i]),
      .q_o     (map_q[i])
    );
  end

  chg_rsp_gen #(
    .MAP_W (MAP_W),
    .SRC_W (SRC_W)
  ) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_tok_i    (in_tok_i),
    .cfg_i       (cfg_i),
    .map_i       (map_q),
    .rsp_valid_o (rsp_valid_o),
    .rsp_nak_o   (rsp_nak_o),
    .rsp_data_o  (rsp_data_o)
  );

  AST_NO_SAMPLE_OFF_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i && !eof_smp_i && !clr_req_i |=> $stable(map_q)); // R2
  AST_CLR_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_vec)); // R4
  AST_UNCFG_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i |=> map_q == '0); // R8
endmodule

// File: tb/hub_chg_reporter_tb_top.sv
module hub_chg_reporter_tb_top;
  localparam int NV = 24;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg, hub_chg, eof, clr, tok;
  logic [3:0] port_chg;
  logic [2:0] clr_idx;
  logic       rsp_valid, rsp_nak;
  logic [7:0] rsp_data;
  int         n_chk = 0;
  int         n_err = 0;

  always #2 clk = ~clk;

  hub_chg_reporter dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_i       (cfg),
    .hub_chg_i   (hub_chg),
    .port_chg_i  (port_chg),
    .eof_smp_i   (eof),
    .clr_req_i   (clr),
    .clr_idx_i   (clr_idx),
    .in_tok_i    (tok),
    .rsp_valid_o (rsp_valid),
    .rsp_nak_o   (rsp_nak),
    .rsp_data_o  (rsp_data)
  );

  // {req[25:22], cfg, hub, port[3:0], eof, tok, clr, idx[2:0], exp_valid, exp_nak, exp_data[7:0]}
  localparam logic [25:0] VEC [NV] = '{
    {4'd8,  1'b0,1'b1,4'b1111,1'b1,1'b0,1'b0,3'd0, 1'b0,1'b0,8'h00}, // R8 no capture
    {4'd8,  1'b0,1'b0,4'b0000,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b1,8'h00}, // R8 NAK
    {4'd7,  1'b1,1'b0,4'b0000,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b1,8'h00}, // R7
    {4'd2,  1'b1,1'b0,4'b0010,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,8'h00}, // R2 off-strobe
    {4'd2,  1'b1,1'b0,4'b0000,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b1,8'h00}, // R2
    {4'd1,  1'b1,1'b0,4'b0010,1'b1,1'b0,1'b0,3'd0, 1'b0,1'b0,8'h00}, // R1 port 2
    {4'd1,  1'b1,1'b0,4'b0000,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b0,8'h04}, // R1
    {4'd3,  1'b1,1'b0,4'b0000,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b0,8'h04}, // R3 repoll
    {4'd1,  1'b1,1'b1,4'b0000,1'b1,1'b0,1'b0,3'd0, 1'b0,1'b0,8'h00}, // R1 hub
    {4'd6,  1'b1,1'b0,4'b0000,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b0,8'h05}, // R6
    {4'd6,  1'b1,1'b0,4'b0000,1'b0,1'b0,1'b1,3'd2, 1'b0,1'b0,8'h00}, // R6 one cycle, R4 clr 2
    {4'd4,  1'b1,1'b0,4'b0000,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b0,8'h01}, // R4
    {4'd4,  1'b1,1'b0,4'b0000,1'b0,1'b0,1'b1,3'd6, 1'b0,1'b0,8'h00}, // R4 bad index
    {4'd4,  1'b1,1'b0,4'b0000,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b0,8'h01}, // R4
    {4'd5,  1'b1,1'b1,4'b0000,1'b1,1'b0,1'b1,3'd0, 1'b0,1'b0,8'h00}, // R5 collide
    {4'd5,  1'b1,1'b0,4'b0000,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b0,8'h01}, // R5
    {4'd4,  1'b1,1'b0,4'b0000,1'b0,1'b0,1'b1,3'd0, 1'b0,1'b0,8'h00}, // R4 clr hub
    {4'd7,  1'b1,1'b0,4'b0000,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b1,8'h00}, // R7
    {4'd9,  1'b1,1'b0,4'b1001,1'b1,1'b1,1'b0,3'd0, 1'b1,1'b1,8'h00}, // R9 tok with capture
    {4'd9,  1'b1,1'b0,4'b0000,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b0,8'h12}, // R9
    {4'd8,  1'b0,1'b0,4'b0000,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,8'h00}, // R8 deconfig
    {4'd8,  1'b1,1'b0,4'b0000,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b1,8'h00}, // R8 flushed
    {4'd1,  1'b1,1'b0,4'b0100,1'b1,1'b0,1'b0,3'd0, 1'b0,1'b0,8'h00}, // R1 port 3
    {4'd1,  1'b1,1'b0,4'b0000,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b0,8'h08}  // R1
  };

  task automatic check(input int req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d: valid/nak/data got %b/%b/%h expected %b/%b/%h",
               req, act[9], act[8], act[7:0], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic drive(input logic c, input logic h, input logic [3:0] p, input logic e,
                       input logic t, input logic cr, input logic [2:0] ci);
    @(negedge clk);
    cfg = c; hub_chg = h; port_chg = p; eof = e; tok = t; clr = cr; clr_idx = ci;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg = 0; hub_chg = 0; port_chg = 0; eof = 0; tok = 0; clr = 0; clr_idx = 0;
    repeat (3) @(posedge clk);
    #1;
    check(10, {rsp_valid, rsp_nak, rsp_data}, 10'b0); // R10 reset outputs
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][21], VEC[i][20], VEC[i][19:16], VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12:10]);
      check(int'(VEC[i][25:22]), {rsp_valid, rsp_nak, rsp_data}, VEC[i][9:0]);
    end

    // R1: all sources at once, reserved bits stay zero
    drive(1, 1, 4'b1111, 1, 0, 0, 0);
    drive(1, 0, 4'b0000, 0, 1, 0, 0);
    check(1, {rsp_valid, rsp_nak, rsp_data}, {1'b1, 1'b0, 8'h1F});
    // R4: index one past last port leaves the bitmap alone
    drive(1, 0, 4'b0000, 0, 0, 1, 5);
    drive(1, 0, 4'b0000, 0, 1, 0, 0);
    check(4, {rsp_valid, rsp_nak, rsp_data}, {1'b1, 1'b0, 8'h1F});
    // R6: the cycle after the response is quiet again
    drive(1, 0, 4'b0000, 0, 0, 0, 0);
    check(6, {rsp_valid, rsp_nak, rsp_data}, 10'b0);
    // R10: reset in mid-run empties the bitmap
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1, 0, 4'b0000, 0, 1, 0, 0);
    check(10, {rsp_valid, rsp_nak, rsp_data}, {1'b1, 1'b1, 8'h00});

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule